// File: doc/BRIEF.md
# Dual-Channel Pulse-Width Modulator with Cycle-Aligned Updates

The block holds two pulse-width modulator channels that run apart from each other. Each channel has an up-counter of up to 16 bits that advances only in cycles where that channel's own clock-enable input is high. Each channel has a programmable period, duty and output polarity. A simple write-only register bus sets these values. While a channel is stopped or waiting to start, a write reaches the working copy at once. While it runs, a write goes into a shadow copy, and the shadow copy moves into the working copy when the counter wraps. Each pulse therefore keeps a consistent shape and never mixes old and new settings.

A channel can start in one of two ways. It starts free-running as soon as software sets its run bit. In synchronous mode it is armed instead and waits for a rising edge on its external start input. That input passes through a two-flop synchronizer first.

Each channel is a three-state machine. STOPPED is the reset state. ARMED means it waits for an external edge. RUN means it is counting. The transitions are:
- start: STOPPED to RUN, when run is set with synchronous mode clear.
- arm: STOPPED to ARMED, when run is set with synchronous mode set.
- trigger: ARMED to RUN, on a synchronized rising edge of the start input.
- halt: any state to STOPPED, when run is cleared.

Top module: `pwm_pair`

## Requirements
- R1: The two channels are independent. A channel's counter advances only on clock cycles where its own `clk_en` bit is high, and writes addressed to one channel leave the other channel unchanged.
- R2: Write address bits [1:0] select the field: 0 is control, 1 is period, 2 is duty. The address bits above bit 1 select the channel. Control bit 0 is run, bit 1 is synchronous mode and bit 2 is polarity. A write with field 3 changes nothing.
- R3: While running, the output is active in every cycle where count < duty. A duty of 0 gives an output that is never active. A duty at or above the period gives an output that is always active.
- R4: The counter starts at 0 when the channel enters RUN, counts up to period-1 and then wraps to 0. A period of 0 or 1 wraps on every enabled cycle.
- R5: Polarity 0 makes the active level high. Polarity 1 makes it low. A channel that is not in RUN drives its inactive level, and after reset both outputs are low.
- R6: In STOPPED or ARMED, a written period, duty or polarity is in effect from the clock edge that takes the write.
- R7: In RUN, written period, duty and polarity values are held and take effect together at the next wrap. If several writes arrive before the wrap, the last one is used.
- R8: Clearing run stops the channel at the edge that takes the write, and the counter returns to 0. Any held values take effect one cycle later.
- R9: With synchronous mode set, setting run arms the channel. It enters RUN three edges after its start input is first sampled high following a low. That is two synchronizer stages plus one edge detect.
- R10: Start-input edges have no effect on a channel that is in STOPPED or RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Channel number in bits [2], field in bits [1:0] |
| wr_data | input | 16 | Write data |
| clk_en | input | 2 | Per-channel count enable |
| ext_start | input | 2 | Per-channel asynchronous start input |
| pwm_out | output | 2 | Per-channel PWM output |

## Verification
Assertions check several properties on every cycle:
- the counter stays below a nonzero period;
- the count holds when the channel's enable is low;
- the working values hold between wraps while the channel runs;
- a stopped or armed channel keeps its count at 0;
- an armed channel stays armed until a start edge arrives;
- the edge detector gives pulses one cycle long.

Only the bench scenarios can show the following:
- that the waveform matches count < duty under each polarity;
- that the shadow values land exactly at the wrap and the last write wins;
- that the start delay is three edges;
- that start edges are ignored outside ARMED and writes to field 3 are ignored.

To show these, the bench compares both outputs against a behavioural model on every cycle.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;

    typedef enum logic [1:0] {
        ST_STOPPED = 2'd0,
        ST_ARMED   = 2'd1,
        ST_RUN     = 2'd2
    } chan_state_t;

    localparam logic [1:0] FLD_CTRL   = 2'd0;
    localparam logic [1:0] FLD_PERIOD = 2'd1;
    localparam logic [1:0] FLD_DUTY   = 2'd2;

    localparam int CTRL_RUN  = 0;
    localparam int CTRL_SYNC = 1;
    localparam int CTRL_POL  = 2;

endpackage

// File: rtl/pwm_start_sync.sv
module pwm_start_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);

    logic [STAGES:0] chain_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-1:0], async_in};
        end
    end

    assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];

    // R9: an edge yields exactly one detect pulse
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_pair_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  logic             start_rise,
    input  logic             wr_ctrl,
    input  logic             wr_period,
    input  logic             wr_duty,
    input  logic [WIDTH-1:0] wr_data,
    output logic             pwm_out
);

    chan_state_t state_q, state_d;

    logic             run_q, sync_q, run_d, sync_d;
    logic             pol_sh_q, pol_sh_d, pol_act_q;
    logic [WIDTH-1:0] per_sh_q, per_sh_d, per_act_q;
    logic [WIDTH-1:0] duty_sh_q, duty_sh_d, duty_act_q;
    logic [WIDTH-1:0] cnt_q;
    logic [WIDTH:0]   cnt_inc;
    logic             wrap;

    // Merge this cycle's write into the held values
    always_comb begin
        run_d     = wr_ctrl   ? wr_data[CTRL_RUN]  : run_q;
        sync_d    = wr_ctrl   ? wr_data[CTRL_SYNC] : sync_q;
        pol_sh_d  = wr_ctrl   ? wr_data[CTRL_POL]  : pol_sh_q;
        per_sh_d  = wr_period ? wr_data            : per_sh_q;
        duty_sh_d = wr_duty   ? wr_data            : duty_sh_q;
    end

    assign cnt_inc = {1'b0, cnt_q} + {{WIDTH{1'b0}}, 1'b1};
    assign wrap    = (state_q == ST_RUN) && clk_en && (cnt_inc >= {1'b0, per_act_q});

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOPPED: begin
                if (run_d && sync_d)       state_d = ST_ARMED;   // arm
                else if (run_d)            state_d = ST_RUN;     // start
            end
            ST_ARMED: begin
                if (!run_d)                state_d = ST_STOPPED; // halt
                else if (start_rise)       state_d = ST_RUN;     // trigger
            end
            ST_RUN: begin
                if (!run_d)                state_d = ST_STOPPED; // halt
            end
            default:                       state_d = ST_STOPPED;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_STOPPED;
        else        state_q <= state_d;
    end

    // Held, working and counter registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q      <= 1'b0;
            sync_q     <= 1'b0;
            pol_sh_q   <= 1'b0;
            per_sh_q   <= '0;
            duty_sh_q  <= '0;
            pol_act_q  <= 1'b0;
            per_act_q  <= '0;
            duty_act_q <= '0;
            cnt_q      <= '0;
        end else begin
            run_q     <= run_d;
            sync_q    <= sync_d;
            pol_sh_q  <= pol_sh_d;
            per_sh_q  <= per_sh_d;
            duty_sh_q <= duty_sh_d;
            if (state_q != ST_RUN) begin
                pol_act_q  <= pol_sh_d;
                per_act_q  <= per_sh_d;
                duty_act_q <= duty_sh_d;
            end else if (wrap) begin
                pol_act_q  <= pol_sh_q;
                per_act_q  <= per_sh_q;
                duty_act_q <= duty_sh_q;
            end
            if (state_q == ST_RUN && state_d == ST_RUN) begin
                if (clk_en) cnt_q <= wrap ? '0 : cnt_inc[WIDTH-1:0];
            end else begin
                cnt_q <= '0;
            end
        end
    end

    // Output process
    always_comb begin
        pwm_out = ((state_q == ST_RUN) && (cnt_q < duty_act_q)) ^ pol_act_q;
    end

    // R4: count stays inside a nonzero period
    a_r4_count_in_period: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && per_act_q != '0) |-> (cnt_q < per_act_q));

    // R7: working values move only at a wrap while running
    a_r7_hold_between_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && $past(state_q) == ST_RUN && !$past(wrap))
        |-> ($stable(per_act_q) && $stable(duty_act_q) && $stable(pol_act_q)));

    // R8: a channel outside RUN keeps its count at zero
    a_r8_idle_count_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_RUN) |-> (cnt_q == '0));

    // R1: no enable, no count
    a_r1_hold_without_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && $past(state_q) == ST_RUN && !$past(clk_en))
        |-> $stable(cnt_q));

    // R9: armed channel waits for its edge
    a_r9_armed_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && !start_rise && run_d) |=> (state_q == ST_ARMED));

endmodule

// File: rtl/pwm_pair.sv
module pwm_pair
    import pwm_pair_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int WIDTH  = 16,
    localparam int CH_BITS = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int ADDR_W  = CH_BITS + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WIDTH-1:0]  wr_data,
    input  logic [NUM_CH-1:0] clk_en,
    input  logic [NUM_CH-1:0] ext_start,
    output logic [NUM_CH-1:0] pwm_out
);

    logic [1:0] field;
    assign field = wr_addr[1:0];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic hit, start_rise;

        assign hit = wr_en && (wr_addr[ADDR_W-1:2] == CH_BITS'(g));

        pwm_start_sync #(.STAGES(2)) u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .async_in (ext_start[g]),
            .rise     (start_rise)
        );

        pwm_channel #(.WIDTH(WIDTH)) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .clk_en     (clk_en[g]),
            .start_rise (start_rise),
            .wr_ctrl    (hit && field == FLD_CTRL),
            .wr_period  (hit && field == FLD_PERIOD),
            .wr_duty    (hit && field == FLD_DUTY),
            .wr_data    (wr_data),
            .pwm_out    (pwm_out[g])
        );
    end

endmodule

// File: tb/pwm_pair_bench.sv
module pwm_pair_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  clk_en = 2'b00;
    logic [1:0]  ext_start = 2'b00;
    logic [1:0]  pwm_out;

    pwm_pair u_pwm_pair (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .clk_en(clk_en), .ext_start(ext_start), .pwm_out(pwm_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int    n_checks = 0;
    int    n_fails  = 0;
    int    cyc      = 0;
    bit    finished = 0;
    bit    rand_en1 = 0;
    logic [7:0] lfsr = 8'hA5;
    string cur_req  = "R5";

    // Behavioural reference (0 stopped, 1 armed, 2 running)
    int m_st[2], m_cnt[2], m_per[2], m_du[2], m_pol[2];
    int h_per[2], h_du[2], h_pol[2], m_run[2], m_syn[2];
    bit sy1[2], sy2[2], sy3[2];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < 2; c++) begin
                m_st[c] = 0; m_cnt[c] = 0; m_per[c] = 0; m_du[c] = 0; m_pol[c] = 0;
                h_per[c] = 0; h_du[c] = 0; h_pol[c] = 0; m_run[c] = 0; m_syn[c] = 0;
                sy1[c] = 0; sy2[c] = 0; sy3[c] = 0;
            end
        end else begin
            for (int c = 0; c < 2; c++) begin
                int nr, ns, np, npe, nd, nst, nct;
                bit rise, wrp;
                nr = m_run[c]; ns = m_syn[c]; np = h_pol[c]; npe = h_per[c]; nd = h_du[c];
                if (wr_en && wr_addr[2] == c[0]) begin
                    case (wr_addr[1:0])
                        2'd0: begin nr = wr_data[0]; ns = wr_data[1]; np = wr_data[2]; end
                        2'd1: npe = wr_data;
                        2'd2: nd = wr_data;
                        default: ;
                    endcase
                end
                rise = sy2[c] && !sy3[c];
                sy3[c] = sy2[c]; sy2[c] = sy1[c]; sy1[c] = ext_start[c];
                wrp = (m_st[c] == 2) && clk_en[c] && (m_cnt[c] + 1 >= m_per[c]);
                nst = m_st[c];
                if (!nr) nst = 0;
                else if (m_st[c] == 0) nst = ns ? 1 : 2;
                else if (m_st[c] == 1 && rise) nst = 2;
                if (m_st[c] == 2 && nst == 2) nct = clk_en[c] ? (wrp ? 0 : m_cnt[c] + 1) : m_cnt[c];
                else nct = 0;
                if (m_st[c] != 2) begin
                    m_per[c] = npe; m_du[c] = nd; m_pol[c] = np;
                end else if (wrp) begin
                    m_per[c] = h_per[c]; m_du[c] = h_du[c]; m_pol[c] = h_pol[c];
                end
                h_per[c] = npe; h_du[c] = nd; h_pol[c] = np;
                m_run[c] = nr; m_syn[c] = ns; m_st[c] = nst; m_cnt[c] = nct;
            end
        end
    end

    task automatic check(string req, logic act, logic exp, string what);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %b expected %b (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // Compare both channels every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            for (int c = 0; c < 2; c++) begin
                logic e;
                e = ((m_st[c] == 2 && m_cnt[c] < m_du[c]) ? 1'b1 : 1'b0) ^ m_pol[c][0];
                check(cur_req, pwm_out[c], e, c == 0 ? "ch0 output" : "ch1 output");
            end
        end
    end

    // Pseudo-random enable for channel 1 (R1)
    always @(negedge clk) begin
        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        if (rand_en1) clk_en[1] <= lfsr[0];
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !finished) begin
            finished = 1;
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_start(input int c);
        @(negedge clk); ext_start[c] = 1'b1;
        repeat (3) @(negedge clk);
        ext_start[c] = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cur_req = "R5";
        check("R5", pwm_out[0], 1'b0, "ch0 after reset");
        check("R5", pwm_out[1], 1'b0, "ch1 after reset");

        // R6 R3 R4: stopped writes apply directly, then free run
        cur_req = "R6";
        clk_en[0] = 1'b1;
        wr(3'b001, 16'd5);
        wr(3'b010, 16'd2);
        cur_req = "R4";
        wr(3'b000, 16'h0001);
        idle(17);

        // R7: several writes while running, last one wins at the wrap
        cur_req = "R7";
        wr(3'b010, 16'd1);
        wr(3'b010, 16'd4);
        wr(3'b001, 16'd7);
        idle(20);

        // R5: polarity change while running is shadowed
        cur_req = "R5";
        wr(3'b000, 16'h0005);
        idle(16);

        // R1: gaps in channel 0 enable
        cur_req = "R1";
        for (int i = 0; i < 12; i++) begin
            @(negedge clk); clk_en[0] = i[0];
        end
        clk_en[0] = 1'b1;

        // R3: duty 0 and duty above period
        cur_req = "R3";
        wr(3'b010, 16'd0);
        idle(16);
        wr(3'b010, 16'd9);
        idle(16);

        // R4: periods of 1 and 0
        cur_req = "R4";
        wr(3'b010, 16'd1);
        wr(3'b001, 16'd1);
        idle(8);
        wr(3'b001, 16'd0);
        idle(8);

        // R2: field 3 writes are ignored
        cur_req = "R2";
        wr(3'b001, 16'd6);
        wr(3'b010, 16'd3);
        idle(10);
        wr(3'b011, 16'hFFFF);
        wr(3'b111, 16'hFFFF);
        idle(12);

        // R8: stop, held values applied afterward
        cur_req = "R8";
        wr(3'b010, 16'd5);
        wr(3'b000, 16'h0004);
        idle(6);
        wr(3'b000, 16'h0000);
        idle(6);

        // R1: channel 1 with random enable, channel 0 untouched
        cur_req = "R1";
        rand_en1 = 1'b1;
        wr(3'b101, 16'd3);
        wr(3'b110, 16'd1);
        wr(3'b100, 16'h0001);
        idle(40);

        // R10: edge while running is ignored
        cur_req = "R10";
        pulse_start(1);
        idle(8);
        wr(3'b100, 16'h0000);
        pulse_start(1);
        idle(8);
        check("R10", pwm_out[1], 1'b0, "ch1 stays stopped after edge");

        // R9: synchronous start
        cur_req = "R9";
        wr(3'b100, 16'h0003);
        idle(10);
        check("R9", pwm_out[1], 1'b0, "ch1 armed inactive");
        pulse_start(1);
        idle(20);
        wr(3'b000, 16'h0003);
        idle(6);
        pulse_start(0);
        idle(20);

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule